// File: doc/BRIEF.md
# DS3 Receive C-Bit Serial Port

This block sits next to a DS3 receive framer. The framer hands it each C-bit it pulls out of the M-frame. Each C-bit arrives as a one-cycle strobe that carries the bit's position (1 to 21) and its value. The block passes a fixed subset of these bits to a serial output. That output is clocked by a gapped clock, which pulses once for each forwarded bit and stays idle for every bit that is not forwarded. Downstream logic samples the serial data on the rising edge of that clock.

Two marker outputs go with the stream. The first is a framing pulse that opens each M-frame's C-bit sequence. The second is an optional data-link mark that covers the three data-link positions. ANDing the data-link mark with the gapped clock gives a clock for the data link alone.

After reset the port stays silent: no clock edges, no framing pulse and no data-link mark. It remains silent until it has seen one complete M-frame, meaning position 1 and then position 21 later on.

Top module: `cbit_rx_port`

## Requirements
- R1: In each armed M-frame the gapped clock `cbit_clk` rises exactly 14 times. There is one rise for each strobe at positions 2, 3, 4, 5, 6 and 13 through 21. Strobes at positions 1 and 7 through 12 give no rise.
- R2: At each rise of `cbit_clk`, `cbit_data` equals the value of the strobe that caused it. `cbit_data` changes one clock cycle before that rise and does not change on the rising cycle.
- R3: `cbit_frame` goes high on the clock edge that registers a position-1 strobe. It goes low on the edge that registers the next position-2 strobe, so it is low before the rise for position 2. It is never high while `cbit_clk` is high.
- R4: When `dl_en` is high, `dl_mark` goes high with the position-13 data and low with the position-16 data. `cbit_clk & dl_mark` therefore rises exactly three times per M-frame, on positions 13, 14 and 15.
- R5: When `dl_en` is low at the forwarded strobes, `dl_mark` stays low.
- R6: A strobe with position 0 or above 21 has no effect on any output.
- R7: While `rst` is high, every output is low on the next clock edge.
- R8: After reset, no output pulses until a position-1 strobe has been followed by a position-21 strobe. Output starts with the M-frame after that.
- R9: Each `cbit_clk` pulse lasts one clock cycle. It starts two clock edges after the strobe is presented: one edge registers the strobe and the next raises the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| c_valid | input | 1 | One-cycle strobe: a C-bit is present |
| c_index | input | 5 | Position of the C-bit in the M-frame, 1 to 21 |
| c_value | input | 1 | Value of the C-bit |
| dl_en | input | 1 | Enables the data-link mark |
| cbit_clk | output | 1 | Gapped serial clock; data is valid on its rising edge |
| cbit_data | output | 1 | Serial C-bit data |
| cbit_frame | output | 1 | Framing pulse that precedes the first forwarded bit |
| dl_mark | output | 1 | Data-link position mark |

## Verification
Errors in the selection decode or the arming state show up within one M-frame. The per-frame count of clock rises drifts away from 14, or pulses appear during the silent frames after reset. A wrong data register or a wrong strobe-to-clock stage shows up at the very next forwarded bit, because the data sampled at that rise no longer matches the value sent. Errors in the marker state show up in the same frame as a framing pulse of the wrong width or at the wrong time, or as a data-link clock count other than three or zero.

// File: rtl/cbit_pkg.sv
package cbit_pkg;
    localparam int IDX_W = 5;
    typedef logic [IDX_W-1:0] cidx_t;

    localparam cidx_t NUM_CBITS  = cidx_t'(21);
    localparam cidx_t FRAME_IDX  = cidx_t'(1);
    localparam cidx_t FIRST_OUT  = cidx_t'(2);
    localparam cidx_t GAP_FIRST  = cidx_t'(7);
    localparam cidx_t GAP_LAST   = cidx_t'(12);
    localparam cidx_t DL_FIRST   = cidx_t'(13);
    localparam cidx_t DL_LAST    = cidx_t'(15);

    typedef struct packed {
        logic  valid;
        cidx_t idx;
        logic  value;
    } cbit_strobe_t;

    function automatic logic idx_legal(cidx_t i);
        return (i >= FRAME_IDX) && (i <= NUM_CBITS);
    endfunction

    function automatic logic idx_forwarded(cidx_t i);
        return idx_legal(i) && (i >= FIRST_OUT) && !((i >= GAP_FIRST) && (i <= GAP_LAST));
    endfunction

    function automatic logic idx_datalink(cidx_t i);
        return (i >= DL_FIRST) && (i <= DL_LAST);
    endfunction
endpackage

// File: rtl/cbit_arm_tracker.sv
module cbit_arm_tracker
    import cbit_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  cbit_strobe_t strb,
    output logic         armed
);
    logic seen_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_start <= 1'b0;
            armed      <= 1'b0;
        end else if (strb.valid) begin
            if (strb.idx == FRAME_IDX)
                seen_start <= 1'b1;
            if (strb.idx == NUM_CBITS && seen_start)
                armed <= 1'b1;
        end
    end
endmodule

// File: rtl/cbit_serializer.sv
module cbit_serializer
    import cbit_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  cbit_strobe_t strb,
    input  logic         armed,
    input  logic         dl_en,
    output logic         ser_clk,
    output logic         ser_data,
    output logic         dl_mark
);
    logic fire;
    logic pend;

    always_comb fire = strb.valid && armed && idx_forwarded(strb.idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            ser_clk  <= 1'b0;
            ser_data <= 1'b0;
            dl_mark  <= 1'b0;
        end else begin
            pend    <= fire;
            ser_clk <= pend;
            if (fire) begin
                ser_data <= strb.value;
                dl_mark  <= dl_en && idx_datalink(strb.idx);
            end
        end
    end
endmodule

// File: rtl/cbit_frame_marker.sv
module cbit_frame_marker
    import cbit_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  cbit_strobe_t strb,
    input  logic         armed,
    output logic         frame_pulse
);
    always_ff @(posedge clk) begin
        if (rst)
            frame_pulse <= 1'b0;
        else if (strb.valid && armed) begin
            if (strb.idx == FRAME_IDX)
                frame_pulse <= 1'b1;
            else if (strb.idx == FIRST_OUT)
                frame_pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/cbit_rx_port.sv
module cbit_rx_port
    import cbit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             c_valid,
    input  logic [IDX_W-1:0] c_index,
    input  logic             c_value,
    input  logic             dl_en,
    output logic             cbit_clk,
    output logic             cbit_data,
    output logic             cbit_frame,
    output logic             dl_mark
);
    cbit_strobe_t strb;
    logic         armed;

    always_comb begin
        strb.valid = c_valid;
        strb.idx   = c_index;
        strb.value = c_value;
    end

    cbit_arm_tracker arm_i (
        .clk   (clk),
        .rst   (rst),
        .strb  (strb),
        .armed (armed)
    );

    cbit_serializer ser_i (
        .clk      (clk),
        .rst      (rst),
        .strb     (strb),
        .armed    (armed),
        .dl_en    (dl_en),
        .ser_clk  (cbit_clk),
        .ser_data (cbit_data),
        .dl_mark  (dl_mark)
    );

    cbit_frame_marker frm_i (
        .clk         (clk),
        .rst         (rst),
        .strb        (strb),
        .armed       (armed),
        .frame_pulse (cbit_frame)
    );
endmodule

// File: rtl/cbit_rx_port_chk.sv
module cbit_rx_port_chk
    import cbit_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             c_valid,
    input logic [IDX_W-1:0] c_index,
    input logic             dl_en,
    input logic             armed,
    input logic             cbit_clk,
    input logic             cbit_data,
    input logic             cbit_frame,
    input logic             dl_mark
);
    assert_clk_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        cbit_clk |=> !cbit_clk);

    assert_data_stable_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cbit_clk) |-> $stable(cbit_data));

    assert_frame_clear_of_clk_R3: assert property (@(posedge clk) disable iff (rst)
        !(cbit_frame && cbit_clk));

    assert_dl_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(dl_mark) |-> $past(dl_en));

    assert_silent_unarmed_R8: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !(cbit_clk || cbit_frame || dl_mark));

    assert_bad_index_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (c_valid && (c_index == '0 || c_index > NUM_CBITS)) |=>
            ($stable(cbit_data) && $stable(dl_mark) && $stable(cbit_frame)));
endmodule

bind cbit_rx_port cbit_rx_port_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .c_valid    (c_valid),
    .c_index    (c_index),
    .dl_en      (dl_en),
    .armed      (armed),
    .cbit_clk   (cbit_clk),
    .cbit_data  (cbit_data),
    .cbit_frame (cbit_frame),
    .dl_mark    (dl_mark)
);

// File: tb/cbit_rx_port_tb_top.sv
module cbit_rx_port_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       c_valid = 1'b0;
    logic [4:0] c_index = '0;
    logic       c_value = 1'b0;
    logic       dl_en = 1'b0;
    logic       cbit_clk, cbit_data, cbit_frame, dl_mark;

    int checks = 0;
    int fails  = 0;

    logic exp_q [0:63];
    int   wr_p = 0;
    int   rd_p = 0;

    logic m_seen = 1'b0;
    logic m_armed = 1'b0;

    logic prev_clk = 1'b0, prev_frame = 1'b0, prev_and = 1'b0;
    int   f_rises = 0, f_dl_rises = 0, f_frames = 0, fp_width = 0;
    int   f_dl_high = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    cbit_rx_port dut_i (
        .clk(clk), .rst(rst), .c_valid(c_valid), .c_index(c_index),
        .c_value(c_value), .dl_en(dl_en), .cbit_clk(cbit_clk),
        .cbit_data(cbit_data), .cbit_frame(cbit_frame), .dl_mark(dl_mark)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit fwd(input int i);
        return (i >= 2 && i <= 6) || (i >= 13 && i <= 21);
    endfunction

    task automatic send(input int idx, input bit val);
        @(negedge clk);
        c_valid = 1'b1;
        c_index = idx[4:0];
        c_value = val;
        if (m_armed && fwd(idx)) begin
            exp_q[wr_p % 64] = val;
            wr_p++;
        end
        if (idx == 1) m_seen = 1'b1;
        if (idx == 21 && m_seen) m_armed = 1'b1;
        @(negedge clk);
        c_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (cbit_clk && !prev_clk) begin
                f_rises++;
                check(rd_p < wr_p, "R1 unexpected clock rise", rd_p, wr_p);
                if (rd_p < wr_p) begin
                    check(cbit_data == exp_q[rd_p % 64], "R2 data at rise",
                          int'(cbit_data), int'(exp_q[rd_p % 64]));
                    rd_p++;
                end
            end
            if (cbit_clk && prev_clk)
                check(1'b0, "R9 clock high two cycles", 2, 1);
            if ((cbit_clk && dl_mark) && !prev_and) f_dl_rises++;
            if (dl_mark) f_dl_high++;
            if (cbit_frame) fp_width++;
            if (cbit_frame && !prev_frame) begin
                f_frames++;
                check(f_rises == 0, "R3 frame pulse before first rise", f_rises, 0);
            end
            if (!cbit_frame && prev_frame) begin
                check(fp_width == 4, "R3 frame pulse width", fp_width, 4);
                check(f_rises == 0, "R3 frame ends before C2 rise", f_rises, 0);
            end
        end
        prev_clk   = cbit_clk;
        prev_frame = cbit_frame;
        prev_and   = cbit_clk && dl_mark;
    end

    task automatic clear_frame;
        f_rises = 0; f_dl_rises = 0; f_frames = 0; fp_width = 0; f_dl_high = 0;
    endtask

    task automatic run_frame(input int fno, input bit en, input bit bad);
        bit arm_at_start;
        arm_at_start = m_armed;
        clear_frame();
        dl_en = en;
        for (int i = 1; i <= 21; i++) begin
            send(i, 1'((fno * 5 + i * 3 + (i >> 2)) >> 1));
            if (bad && i == 6) begin
                send(0, 1'b1);
                send(22, 1'b1);
                send(31, 1'b0);
            end
        end
        repeat (2) @(negedge clk);
        if (arm_at_start) begin
            check(f_rises == 14, "R1 rises per frame", f_rises, 14);
            check(f_frames == 1, "R3 frame pulses per frame", f_frames, 1);
            if (en)
                check(f_dl_rises == 3, "R4 data-link clock rises", f_dl_rises, 3);
            else begin
                check(f_dl_rises == 0, "R5 data-link rises while disabled", f_dl_rises, 0);
                check(f_dl_high == 0, "R5 mark high while disabled", f_dl_high, 0);
            end
            if (bad)
                check(rd_p == wr_p, "R6 bad index left queue in step", rd_p, wr_p);
        end else begin
            check(f_rises == 0 && f_frames == 0 && f_dl_high == 0,
                  "R8 silent before full frame", f_rises + f_frames + f_dl_high, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cbit_clk == 0 && cbit_data == 0 && cbit_frame == 0 && dl_mark == 0,
              "R7 outputs low in reset",
              int'({cbit_clk, cbit_data, cbit_frame, dl_mark}), 0);
        rst = 1'b0;
        dl_en = 1'b1;
        clear_frame();
        for (int i = 10; i <= 21; i++) send(i, 1'b1);
        repeat (2) @(negedge clk);
        check(f_rises == 0 && f_dl_high == 0, "R8 partial frame does not arm",
              f_rises + f_dl_high, 0);
        run_frame(0, 1'b1, 1'b0);
        for (int f = 1; f <= 8; f++) run_frame(f, f[0], f == 3 || f == 6);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(cbit_clk == 0 && cbit_frame == 0 && dl_mark == 0 && cbit_data == 0,
              "R7 outputs low after mid-run reset",
              int'({cbit_clk, cbit_data, cbit_frame, dl_mark}), 0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) check(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule